// File: doc/BRIEF.md
# UART register and FIFO controller

This block is the software-facing half of a serial port. A simple synchronous bus port (address, write data, write strobe, read strobe, read data) reaches a small set of word-aligned registers that hold the character format, the baud divisor, a low-power divisor and a global enable. It also gives access to a transmit FIFO and a receive FIFO. Characters written by software are queued and handed to an external transmit shifter through a valid/ready pair. Characters from an external receive shifter arrive with four error bits and are queued until software reads them.

One address acts as the data port. A write queues a character for transmission. A read pops the oldest received character along with its error bits. A separate status register keeps the error bits of the character most recently popped, and any write to it clears them. A read-only flag register reports whether each FIFO is full or empty and whether the transmitter is busy. When the FIFO-enable bit is clear, each FIFO holds a single entry. Clearing that bit while it is set discards everything waiting to be transmitted. The divisor registers take effect only when the line-control register is next written.

Top module: `uart_regs_ctrl`

## Requirements
- R1: After reset every register reads zero except the flag register, which reads 0x90 (transmit empty bit 7 and receive empty bit 4 set). The enable is off and no character is offered to the transmit shifter.
- R2: Register byte offsets are: data 0x00, receive status 0x04, flags 0x18, low-power divisor 0x20, integer divisor 0x24, fractional divisor 0x28, line control 0x2C, control 0x30. Address bits [1:0] are ignored. Offsets 0x08-0x14 and 0x1C read zero and ignore writes. Writes to the flag register are ignored. rdata_o combinationally shows the register selected by addr_i. re_i is ignored while we_i is high.
- R3: A write to offset 0x00 queues wdata_i[7:0]. While enabled (control bit 0 set) and the queue is non-empty, tx_valid_o is high and tx_data_o shows the oldest character. Each cycle with tx_valid_o and tx_ready_i both high removes it. Characters leave in the order they were written.
- R4: Flag bit 5 (transmit full) is set when the transmit FIFO holds 16 characters with FIFO-enable (line-control bit 4) set, or 1 character with it clear. A data write while the FIFO is full is dropped.
- R5: A read of offset 0x00 pops the oldest received entry and returns {error[3:0] in bits 11:8, character in bits 7:0}. Reading while the receive FIFO is empty returns zero and changes nothing. Flag bit 4 is set when the receive FIFO is empty, and flag bit 6 when it is full (same 16-or-1 rule as R4).
- R6: The receive status register (bits 3:0 = overrun, break, parity, framing) takes the error bits of each popped entry. Any write to offset 0x04 clears it.
- R7: A received character offered while the receive FIFO is full is dropped and sets status bit 3, even if the FIFO is popped in the same cycle.
- R8: Writing line control with bit 4 clear while FIFO-enable is set empties the transmit FIFO in that cycle.
- R9: Flag bit 3 (busy) is set while the transmit FIFO is non-empty or tx_active_i is high.
- R10: While the enable is off, tx_valid_o stays low and received characters are ignored. Data writes still queue.
- R11: Line control holds bit 1 parity enable, bit 2 even parity, bit 3 two stop bits, bits 6:5 word length (00 = 5 up to 11 = 8 bits) and bit 7 stick parity; bit 0 reads zero. The integer (16-bit) and fractional (6-bit) divisor registers read back at once, but div_int_o and div_frac_o take their values only on a line-control write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| addr_i | input | 6 | Byte address of the register |
| wdata_i | input | 32 | Write data |
| we_i | input | 1 | Write strobe |
| re_i | input | 1 | Read strobe (pops the receive FIFO at offset 0x00) |
| rdata_o | output | 32 | Read data for the addressed register |
| tx_data_o | output | 8 | Character offered to the transmit shifter |
| tx_valid_o | output | 1 | tx_data_o is valid |
| tx_ready_i | input | 1 | Transmit shifter takes the character |
| tx_active_i | input | 1 | Transmit shifter is sending a character |
| rx_valid_i | input | 1 | Receive shifter delivers a character |
| rx_data_i | input | 8 | Received character |
| rx_err_i | input | 4 | Error bits {overrun, break, parity, framing} of the character |
| uart_en_o | output | 1 | Global enable |
| word_len_o | output | 2 | Word length code |
| parity_en_o | output | 1 | Parity enable |
| even_par_o | output | 1 | Even parity select |
| stick_par_o | output | 1 | Stick parity select |
| two_stop_o | output | 1 | Two stop bits |
| div_int_o | output | 16 | Active integer baud divisor |
| div_frac_o | output | 6 | Active fractional baud divisor |
| lp_div_o | output | 8 | Low-power divisor |

## Verification
The hardest case to reach is a receive push that arrives while the FIFO is full and is popped in the same cycle. The push must still be dropped, and the status must combine the popped entry's errors with the overrun bit. The bench gets there by switching to one-entry mode, loading a single character, and then driving a data read and a receive strobe in the same cycle. A second hard case is the flush. Several characters are queued with the shifter held not-ready, and line control is then rewritten with FIFO-enable clear. The bench checks that the queued characters are never offered to the shifter.

// File: rtl/uart_regs_pkg.sv
package uart_regs_pkg;
  localparam int ADDR_W = 6;
  localparam int DATA_W = 32;
  localparam int CHAR_W = 8;
  localparam int ERR_W  = 4;

  // word index = byte offset / 4
  localparam logic [3:0] IDX_DATA = 4'h0;
  localparam logic [3:0] IDX_RSR  = 4'h1;
  localparam logic [3:0] IDX_FLAG = 4'h6;
  localparam logic [3:0] IDX_LPC  = 4'h8;
  localparam logic [3:0] IDX_DIVI = 4'h9;
  localparam logic [3:0] IDX_DIVF = 4'hA;
  localparam logic [3:0] IDX_LINE = 4'hB;
  localparam logic [3:0] IDX_CTRL = 4'hC;

  localparam int ERR_OVR = 3;

  typedef struct packed {
    logic [ERR_W-1:0]  err;
    logic [CHAR_W-1:0] data;
  } rx_entry_t;

  typedef struct packed {
    logic       stick;
    logic [1:0] wlen;
    logic       fifo_en;
    logic       two_stop;
    logic       even;
    logic       par_en;
    logic       rsvd;
  } line_ctrl_t;
endpackage

// File: rtl/uart_fifo.sv
module uart_fifo #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 16,
  localparam int PW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             single_i,
  input  logic             flush_i,
  input  logic             push_i,
  input  logic [WIDTH-1:0] data_i,
  input  logic             pop_i,
  output logic [WIDTH-1:0] data_o,
  output logic             empty_o,
  output logic             full_o,
  output logic [CW-1:0]    count_o
);
  logic [WIDTH-1:0] mem_q [DEPTH];
  logic [PW-1:0]    wr_ptr_q, rd_ptr_q;
  logic [CW-1:0]    cnt_q;
  logic             push_ok, pop_ok;

  assign empty_o = (cnt_q == '0);
  assign full_o  = single_i ? (cnt_q != '0) : (cnt_q == CW'(DEPTH));
  assign push_ok = push_i && !full_o && !flush_i;
  assign pop_ok  = pop_i && !empty_o && !flush_i;
  assign data_o  = mem_q[rd_ptr_q];
  assign count_o = cnt_q;

  always_ff @(posedge clk_i) begin
    if (push_ok) mem_q[wr_ptr_q] <= data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else if (flush_i) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      if (push_ok) wr_ptr_q <= wr_ptr_q + 1'b1;
      if (pop_ok)  rd_ptr_q <= rd_ptr_q + 1'b1;
      case ({push_ok, pop_ok})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  assert_no_overflow_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CW'(DEPTH));
  assert_full_push_dropped_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && full_o && !pop_i && !flush_i) |=> $stable(cnt_q));
  assert_flush_empties_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> empty_o);
endmodule

// File: rtl/uart_cfg_regs.sv
module uart_cfg_regs
  import uart_regs_pkg::*;
#(
  parameter int DIV_IW = 16,
  parameter int DIV_FW = 6,
  parameter int LP_W   = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [3:0]        widx_i,
  input  logic [15:0]       wdata_i,
  output line_ctrl_t        line_o,
  output logic              en_o,
  output logic [LP_W-1:0]   lp_o,
  output logic [DIV_IW-1:0] divi_o,
  output logic [DIV_FW-1:0] divf_o,
  output logic [DIV_IW-1:0] div_int_o,
  output logic [DIV_FW-1:0] div_frac_o,
  output logic              line_wr_o
);
  assign line_wr_o = wr_i && (widx_i == IDX_LINE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      line_o     <= '0;
      en_o       <= 1'b0;
      lp_o       <= '0;
      divi_o     <= '0;
      divf_o     <= '0;
      div_int_o  <= '0;
      div_frac_o <= '0;
    end else if (wr_i) begin
      case (widx_i)
        IDX_LPC:  lp_o   <= wdata_i[LP_W-1:0];
        IDX_DIVI: divi_o <= wdata_i[DIV_IW-1:0];
        IDX_DIVF: divf_o <= wdata_i[DIV_FW-1:0];
        IDX_CTRL: en_o   <= wdata_i[0];
        IDX_LINE: begin
          line_o     <= line_ctrl_t'(wdata_i[7:0] & 8'hFE);
          div_int_o  <= divi_o;   // divisors commit on line-control write
          div_frac_o <= divf_o;
        end
        default: ;
      endcase
    end
  end

  assert_div_held_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !line_wr_o |=> ($stable(div_int_o) && $stable(div_frac_o)));
endmodule

// File: rtl/uart_regs_ctrl.sv
module uart_regs_ctrl
  import uart_regs_pkg::*;
#(
  parameter int FIFO_DEPTH = 16,
  localparam int CW = $clog2(FIFO_DEPTH + 1)
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic [5:0]  addr_i,
  input  logic [31:0] wdata_i,
  input  logic        we_i,
  input  logic        re_i,
  output logic [31:0] rdata_o,
  output logic [7:0]  tx_data_o,
  output logic        tx_valid_o,
  input  logic        tx_ready_i,
  input  logic        tx_active_i,
  input  logic        rx_valid_i,
  input  logic [7:0]  rx_data_i,
  input  logic [3:0]  rx_err_i,
  output logic        uart_en_o,
  output logic [1:0]  word_len_o,
  output logic        parity_en_o,
  output logic        even_par_o,
  output logic        stick_par_o,
  output logic        two_stop_o,
  output logic [15:0] div_int_o,
  output logic [5:0]  div_frac_o,
  output logic [7:0]  lp_div_o
);
  logic [3:0]  widx;
  line_ctrl_t  line;
  logic [15:0] divi;
  logic [5:0]  divf;
  logic        line_wr, flush;
  logic        tx_empty, tx_full;
  logic        rx_empty, rx_full, rx_push, rx_pop, rx_pop_ok, rx_drop, wr_rsr;
  rx_entry_t   rx_head;
  logic [CW-1:0] rx_cnt, unused_tx_cnt;
  logic [ERR_W-1:0] rsr_q;
  logic        busy;
  logic        unused_bits;

  assign widx        = addr_i[5:2];
  assign unused_bits = ^{addr_i[1:0], wdata_i[31:16]};

  uart_cfg_regs u_cfg (
    .clk_i, .rst_ni,
    .wr_i      (we_i),
    .widx_i    (widx),
    .wdata_i   (wdata_i[15:0]),
    .line_o    (line),
    .en_o      (uart_en_o),
    .lp_o      (lp_div_o),
    .divi_o    (divi),
    .divf_o    (divf),
    .div_int_o,
    .div_frac_o,
    .line_wr_o (line_wr)
  );

  assign word_len_o  = line.wlen;
  assign parity_en_o = line.par_en;
  assign even_par_o  = line.even;
  assign stick_par_o = line.stick;
  assign two_stop_o  = line.two_stop;

  // clearing FIFO enable drops pending transmit data
  assign flush = line_wr && !wdata_i[4] && line.fifo_en;

  assign tx_valid_o = uart_en_o && !tx_empty;

  uart_fifo #(.WIDTH(CHAR_W), .DEPTH(FIFO_DEPTH)) u_tx_fifo (
    .clk_i, .rst_ni,
    .single_i (!line.fifo_en),
    .flush_i  (flush),
    .push_i   (we_i && widx == IDX_DATA),
    .data_i   (wdata_i[CHAR_W-1:0]),
    .pop_i    (tx_valid_o && tx_ready_i),
    .data_o   (tx_data_o),
    .empty_o  (tx_empty),
    .full_o   (tx_full),
    .count_o  (unused_tx_cnt)
  );

  assign rx_push   = rx_valid_i && uart_en_o;
  assign rx_pop    = re_i && !we_i && widx == IDX_DATA;
  assign rx_pop_ok = rx_pop && !rx_empty;
  assign rx_drop   = rx_push && rx_full;
  assign wr_rsr    = we_i && widx == IDX_RSR;

  uart_fifo #(.WIDTH($bits(rx_entry_t)), .DEPTH(FIFO_DEPTH)) u_rx_fifo (
    .clk_i, .rst_ni,
    .single_i (!line.fifo_en),
    .flush_i  (1'b0),
    .push_i   (rx_push),
    .data_i   ({rx_err_i, rx_data_i}),
    .pop_i    (rx_pop),
    .data_o   (rx_head),
    .empty_o  (rx_empty),
    .full_o   (rx_full),
    .count_o  (rx_cnt)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsr_q <= '0;
    end else begin
      if (rx_pop_ok) rsr_q <= rx_head.err;
      if (wr_rsr)    rsr_q <= '0;
      if (rx_drop)   rsr_q[ERR_OVR] <= 1'b1;
    end
  end

  assign busy = !tx_empty || tx_active_i;

  always_comb begin
    rdata_o = '0;
    case (widx)
      IDX_DATA: rdata_o = rx_empty ? '0 : DATA_W'(rx_head);
      IDX_RSR:  rdata_o = DATA_W'(rsr_q);
      IDX_FLAG: rdata_o = DATA_W'({tx_empty, rx_full, tx_full, rx_empty, busy, 3'b000});
      IDX_LPC:  rdata_o = DATA_W'(lp_div_o);
      IDX_DIVI: rdata_o = DATA_W'(divi);
      IDX_DIVF: rdata_o = DATA_W'(divf);
      IDX_LINE: rdata_o = DATA_W'(line);
      IDX_CTRL: rdata_o = DATA_W'(uart_en_o);
      default:  rdata_o = '0;
    endcase
  end

  assert_overrun_sets_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_drop |=> rsr_q[ERR_OVR]);
  assert_rsr_clear_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_rsr && !rx_drop) |=> (rsr_q == '0));
  assert_rx_ignored_off_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!uart_en_o && !rx_pop) |=> $stable(rx_cnt));
  assert_tx_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_valid_o && !tx_ready_i && !flush) |=> (tx_valid_o && $stable(tx_data_o)));
endmodule

// File: tb/uart_regs_ctrl_test.sv
`timescale 1ns/1ps
module uart_regs_ctrl_test;
  logic clk_i = 0, rst_ni = 0;
  logic [5:0] addr = 0;
  logic [31:0] wdata = 0, rdata;
  logic we = 0, re = 0;
  logic [7:0] tx_data; logic tx_valid; logic tx_ready = 0, tx_active = 0;
  logic rx_valid = 0; logic [7:0] rx_data = 0; logic [3:0] rx_err = 0;
  logic uart_en, par_en, even_par, stick_par, two_stop;
  logic [1:0] word_len; logic [15:0] div_int; logic [5:0] div_frac; logic [7:0] lp_div;

  int checks = 0, fails = 0;

  always #10 clk_i = ~clk_i;

  uart_regs_ctrl uut (
    .clk_i, .rst_ni, .addr_i(addr), .wdata_i(wdata), .we_i(we), .re_i(re),
    .rdata_o(rdata), .tx_data_o(tx_data), .tx_valid_o(tx_valid),
    .tx_ready_i(tx_ready), .tx_active_i(tx_active), .rx_valid_i(rx_valid),
    .rx_data_i(rx_data), .rx_err_i(rx_err), .uart_en_o(uart_en),
    .word_len_o(word_len), .parity_en_o(par_en), .even_par_o(even_par),
    .stick_par_o(stick_par), .two_stop_o(two_stop), .div_int_o(div_int),
    .div_frac_o(div_frac), .lp_div_o(lp_div));

  // reference model
  logic [7:0]  txq[$];
  logic [11:0] rxq[$];
  logic [7:0]  m_lp, m_lcr; logic [15:0] m_divi, m_dint; logic [5:0] m_divf, m_dfrac;
  logic m_en; logic [3:0] m_rsr, n_rsr;
  logic m_txfull, m_rxfull, m_pop, m_drop; logic [11:0] m_head;

  function automatic logic [31:0] model_read(input logic [5:0] a);
    logic txff, rxff;
    txff = m_lcr[4] ? (txq.size() == 16) : (txq.size() >= 1);
    rxff = m_lcr[4] ? (rxq.size() == 16) : (rxq.size() >= 1);
    case (a[5:2])
      4'h0: return rxq.size() == 0 ? 32'h0 : {20'h0, rxq[0]};
      4'h1: return {28'h0, m_rsr};
      4'h6: return {24'h0, txq.size() == 0, rxff, txff, rxq.size() == 0,
                    (txq.size() > 0) || tx_active, 3'b000};
      4'h8: return {24'h0, m_lp};
      4'h9: return {16'h0, m_divi};
      4'hA: return {26'h0, m_divf};
      4'hB: return {24'h0, m_lcr};
      4'hC: return {31'h0, m_en};
      default: return 32'h0;
    endcase
  endfunction

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      txq.delete(); rxq.delete();
      m_lp = 0; m_lcr = 0; m_divi = 0; m_dint = 0; m_divf = 0; m_dfrac = 0;
      m_en = 0; m_rsr = 0;
    end else begin
      m_txfull = m_lcr[4] ? (txq.size() == 16) : (txq.size() >= 1);
      m_rxfull = m_lcr[4] ? (rxq.size() == 16) : (rxq.size() >= 1);
      if (we && addr[5:2] == 4'hB && !wdata[4] && m_lcr[4]) txq.delete();
      else begin
        if (m_en && txq.size() > 0 && tx_ready) void'(txq.pop_front());
        if (we && addr[5:2] == 4'h0 && !m_txfull) txq.push_back(wdata[7:0]);
      end
      m_pop  = re && !we && addr[5:2] == 4'h0 && rxq.size() > 0;
      m_drop = rx_valid && m_en && m_rxfull;
      m_head = m_pop ? rxq[0] : 12'h0;
      if (m_pop) void'(rxq.pop_front());
      if (rx_valid && m_en && !m_rxfull) rxq.push_back({rx_err, rx_data});
      n_rsr = m_rsr;
      if (m_pop) n_rsr = m_head[11:8];
      if (we && addr[5:2] == 4'h1) n_rsr = 0;
      if (m_drop) n_rsr[3] = 1'b1;
      m_rsr = n_rsr;
      if (we) case (addr[5:2])
        4'h8: m_lp = wdata[7:0];
        4'h9: m_divi = wdata[15:0];
        4'hA: m_divf = wdata[5:0];
        4'hB: begin m_lcr = wdata[7:0] & 8'hFE; m_dint = m_divi; m_dfrac = m_divf; end
        4'hC: m_en = wdata[0];
        default: ;
      endcase
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk_i) if (rst_ni) begin
    #5;
    chk("R3 tx port", {tx_valid, (tx_valid ? tx_data : 8'h0)},
        {(m_en && txq.size() > 0), ((m_en && txq.size() > 0) ? txq[0] : 8'h0)});
    chk("R11 config", {uart_en, word_len, par_en, even_par, stick_par, two_stop, div_int, div_frac, lp_div},
        {m_en, m_lcr[6:5], m_lcr[1], m_lcr[2], m_lcr[7], m_lcr[3], m_dint, m_dfrac, m_lp});
    if (re && !we) chk("R2 read data", rdata, model_read(addr));
  end

  task automatic bus(input logic w, input logic r, input logic [5:0] a, input logic [31:0] d,
                     input logic rv = 0, input logic [7:0] rd = 0, input logic [3:0] e = 0);
    @(negedge clk_i);
    we = w; re = r; addr = a; wdata = d; rx_valid = rv; rx_data = rd; rx_err = e;
    @(posedge clk_i); #1;
    we = 0; re = 0; rx_valid = 0;
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d); bus(1, 0, a, d); endtask
  task automatic rx(input logic [7:0] d, input logic [3:0] e); bus(0, 0, 0, 0, 1, d, e); endtask

  task automatic rd_expect(input logic [5:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk_i);
    re = 1; addr = a;
    #5 chk(tag, rdata, exp);
    @(posedge clk_i); #1;
    re = 0;
  endtask

  initial begin
    #(20 * 150000);
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk_i);
    rst_ni = 1;
    repeat (2) @(posedge clk_i);
    // R1 reset state
    rd_expect(6'h18, 32'h90, "R1 flags");
    rd_expect(6'h00, 32'h0, "R1 data");
    rd_expect(6'h30, 32'h0, "R1 ctrl");
    rd_expect(6'h2C, 32'h0, "R1 line");
    // R11 divisor commit
    wr(6'h24, 32'hFFFF1234);
    wr(6'h28, 32'hFF);
    wr(6'h20, 32'h1AB);
    chk("R11 div held", {16'h0, div_int}, 32'h0);
    rd_expect(6'h28, 32'h3F, "R11 frac readback");
    rd_expect(6'h26, 32'h1234, "R2 low addr bits ignored");
    wr(6'h2C, 32'hF1);
    chk("R11 div committed", {10'h0, div_int, div_frac}, {10'h0, 16'h1234, 6'h3F});
    chk("R11 word len", {30'h0, word_len}, 32'h3);
    rd_expect(6'h2C, 32'hF0, "R11 line bit0 zero");
    // R2 reserved and read-only
    wr(6'h08, 32'hFFFFFFFF);
    wr(6'h1C, 32'hFFFFFFFF);
    rd_expect(6'h08, 32'h0, "R2 reserved 08");
    rd_expect(6'h1C, 32'h0, "R2 reserved 1C");
    wr(6'h18, 32'h0);
    rd_expect(6'h18, 32'h90, "R2 flag write ignored");
    // R4 fill while disabled
    for (int i = 0; i < 17; i++) wr(6'h00, 32'h30 + i);
    rd_expect(6'h18, 32'h38, "R4 tx full");
    chk("R10 tx held while off", {31'h0, tx_valid}, 32'h0);
    // R3 drain in order
    wr(6'h30, 32'h1);
    chk("R3 first char", {23'h0, tx_valid, tx_data}, {23'h0, 1'b1, 8'h30});
    @(negedge clk_i); tx_ready = 1;
    repeat (20) @(posedge clk_i);
    @(negedge clk_i); tx_ready = 0;
    rd_expect(6'h18, 32'h90, "R3 drained");
    // R9 busy from shifter
    @(negedge clk_i); tx_active = 1;
    rd_expect(6'h18, 32'h98, "R9 busy");
    @(negedge clk_i); tx_active = 0;
    // R4 single-entry mode
    wr(6'h2C, 32'h60);
    wr(6'h00, 32'h55);
    wr(6'h00, 32'h66);
    rd_expect(6'h18, 32'h38, "R4 single full");
    chk("R4 second dropped", {24'h0, tx_data}, 32'h55);
    @(negedge clk_i); tx_ready = 1;
    @(negedge clk_i); tx_ready = 0;
    // R8 flush
    wr(6'h2C, 32'h70);
    for (int i = 0; i < 4; i++) wr(6'h00, 32'h77 + i);
    wr(6'h2C, 32'h60);
    rd_expect(6'h18, 32'h90, "R8 flushed");
    chk("R8 no tx after flush", {31'h0, tx_valid}, 32'h0);
    // R5 / R6 receive path
    wr(6'h2C, 32'h70);
    rx(8'h41, 4'b0001);
    rx(8'h42, 4'b0110);
    rd_expect(6'h18, 32'h80, "R5 rx not empty");
    rd_expect(6'h00, 32'h141, "R5 pop first");
    rd_expect(6'h04, 32'h1, "R6 status first");
    rd_expect(6'h00, 32'h642, "R5 pop second");
    rd_expect(6'h04, 32'h6, "R6 status second");
    rd_expect(6'h00, 32'h0, "R5 empty read");
    rd_expect(6'h04, 32'h6, "R6 status kept after empty read");
    wr(6'h04, 32'h0);
    rd_expect(6'h04, 32'h0, "R6 cleared");
    // R7 overrun
    for (int i = 0; i < 17; i++) rx(8'h10 + i[7:0], 4'h0);
    rd_expect(6'h18, 32'hC0, "R7 rx full");
    rd_expect(6'h04, 32'h8, "R7 overrun set");
    for (int i = 0; i < 16; i++) rd_expect(6'h00, 32'h10 + i, "R7 kept order");
    rd_expect(6'h00, 32'h0, "R7 extra dropped");
    // R7 push with simultaneous pop on full single entry
    wr(6'h2C, 32'h60);
    rx(8'h21, 4'h0);
    bus(0, 1, 6'h00, 0, 1, 8'h22, 4'h0);
    rd_expect(6'h04, 32'h8, "R7 same-cycle drop");
    rd_expect(6'h18, 32'h90, "R7 nothing stored");
    // R10 disabled
    wr(6'h04, 32'h0);
    wr(6'h30, 32'h0);
    rx(8'h99, 4'h0);
    rd_expect(6'h18, 32'h90, "R10 rx ignored");
    wr(6'h00, 32'h5A);
    chk("R10 tx not offered", {31'h0, tx_valid}, 32'h0);
    rd_expect(6'h18, 32'h38, "R10 tx still queued");
    repeat (2) @(posedge clk_i);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule